// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins two W-bit buses, called A and B, through two storage paths that do not invert data. One path carries A to B and the other carries B to A. Each path has three controls of its own: an output enable that is active low, a latch enable, and a clock. Each path can pass data straight through, hold a stored word, or load a new word on a rising clock edge. The output of each path drives the opposite bus through tri-state drivers.

When a latch enable is high, its path is transparent. When the latch enable goes low, the path keeps the last word it saw and then changes only on rising edges of its clock. The buses are inout ports. When an output enable is high, that path releases its bus so another agent can drive it.

Top module: `bus_xcvr`

## Requirements
- R1: Each path copies its source bus to the opposite bus bit for bit, with no inversion, on all W bits (default 18).
- R2: When a path's output enable is low and its latch enable is high, the opposite bus follows the source bus continuously.
- R3: When the latch enable is low and the clock stays low, or stays high, the driven output keeps its value while the source bus changes.
- R4: When the latch enable is low, a rising clock edge loads the current source bus value, and the output shows that value from then on.
- R5: When the latch enable goes from high to low, the output keeps the last source value that was present during transparency.
- R6: A falling clock edge leaves the stored value unchanged.
- R7: A rising clock edge while the latch enable is high has no visible effect, because the output still follows the source.
- R8: When a path's output enable is high, that path does not drive its bus, and a value driven from outside can be read back on that bus unchanged.
- R9: When the output enable goes from high back to low, the stored value appears on the bus again.
- R10: Activity on one path's controls and source bus leaves the other path's stored value unchanged.
- R11: When both output enables are low and both latch enables are low, bus B shows the A-to-B stored value and bus A shows the B-to-A stored value. Both paths being enabled and transparent at the same time is forbidden.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_io | inout | W | Bus A: source of the A-to-B path, and driven by the B-to-A path |
| b_io | inout | W | Bus B: source of the B-to-A path, and driven by the A-to-B path |
| oe_ab_n | input | 1 | Drive enable for bus B from the A-to-B path, active low |
| le_ab | input | 1 | A-to-B transparency enable, active high |
| cp_ab | input | 1 | A-to-B load clock, acts on the rising edge |
| oe_ba_n | input | 1 | Drive enable for bus A from the B-to-A path, active low |
| le_ba | input | 1 | B-to-A transparency enable, active high |
| cp_ba | input | 1 | B-to-A load clock, acts on the rising edge |

## Verification
The bench builds the block with its default width of 18. This lets random 18-bit words set and clear every bit of both buses in both directions. The same two routines run each mode on either path, so transparency, holding at both clock levels, edge loading, a falling edge and bus release are all covered on both A-to-B and B-to-A. The bench then swaps the stored words across both buses at once. This shows that the two paths keep separate storage.

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int W = 18
) (
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io,
  input  logic         oe_ab_n,
  input  logic         le_ab,
  input  logic         cp_ab,
  input  logic         oe_ba_n,
  input  logic         le_ba,
  input  logic         cp_ba
);

  localparam logic [W-1:0] HIZ = {W{1'bz}};

  logic [W-1:0] st_ab, st_ba;
  logic [W-1:0] out_ab, out_ba;

  // storage loads on a rising clock; a falling latch enable freezes the last transparent word
  always_ff @(posedge cp_ab or negedge le_ab) st_ab <= a_io;
  always_ff @(posedge cp_ba or negedge le_ba) st_ba <= b_io;

  assign out_ab = le_ab ? a_io : st_ab;
  assign out_ba = le_ba ? b_io : st_ba;

  assign b_io = oe_ab_n ? HIZ : out_ab;
  assign a_io = oe_ba_n ? HIZ : out_ba;

  a_r2_flow_ab: assert property (@(posedge cp_ab) disable iff (oe_ab_n)
    le_ab |-> (b_io == a_io));

  a_r2_flow_ba: assert property (@(posedge cp_ba) disable iff (oe_ba_n)
    le_ba |-> (a_io == b_io));

  a_r4_capture_ab: assert property (@(posedge cp_ab) disable iff (le_ab)
    1'b1 |=> (st_ab == $past(a_io)));

  a_r4_capture_ba: assert property (@(posedge cp_ba) disable iff (le_ba)
    1'b1 |=> (st_ba == $past(b_io)));

  a_r11_no_loop: assert property (@(posedge cp_ab) disable iff (oe_ab_n)
    !(le_ab && le_ba && !oe_ba_n));

endmodule

// File: tb/sim_bus_xcvr.sv
module sim_bus_xcvr;
  localparam int W = 18;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a_drv, b_drv;
  logic a_en, b_en;
  logic oe_ab_n, le_ab, cp_ab, oe_ba_n, le_ba, cp_ba;
  wire  [W-1:0] a_io, b_io;

  assign a_io = a_en ? a_drv : {W{1'bz}};
  assign b_io = b_en ? b_drv : {W{1'bz}};

  bus_xcvr #(.W(W)) u0 (
    .a_io(a_io), .b_io(b_io),
    .oe_ab_n(oe_ab_n), .le_ab(le_ab), .cp_ab(cp_ab),
    .oe_ba_n(oe_ba_n), .le_ba(le_ba), .cp_ba(cp_ba)
  );

  int checks = 0;
  int errors = 0;
  logic [W-1:0] held_ab, held_ba;

  function automatic logic [W-1:0] rnd();
    return W'($urandom());
  endfunction

  function automatic logic [W-1:0] expect_out(input logic le, input logic [W-1:0] src,
                                              input logic [W-1:0] held);
    return le ? src : held;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic set_src(input bit ab, input logic [W-1:0] v);
    if (ab) a_drv = v; else b_drv = v;
  endtask
  task automatic set_le(input bit ab, input logic v);
    if (ab) le_ab = v; else le_ba = v;
  endtask
  task automatic set_cp(input bit ab, input logic v);
    if (ab) cp_ab = v; else cp_ba = v;
  endtask
  task automatic set_oe_n(input bit ab, input logic v);
    if (ab) oe_ab_n = v; else oe_ba_n = v;
  endtask
  task automatic set_dst_drive(input bit ab, input logic en, input logic [W-1:0] v);
    if (ab) begin b_en = en; b_drv = v; end else begin a_en = en; a_drv = v; end
  endtask
  function automatic logic [W-1:0] dst(input bit ab);
    return ab ? b_io : a_io;
  endfunction

  task automatic run_path(input bit ab, output logic [W-1:0] final_held);
    logic [W-1:0] src, held;
    step();
    set_dst_drive(ab, 1'b0, '0);
    set_cp(ab, 1'b0);
    set_le(ab, 1'b1);
    set_oe_n(ab, 1'b0);
    src = '0;
    held = '0;
    for (int i = 0; i < 6; i++) begin
      step(); src = (i == 0) ? '1 : (i == 1) ? '0 : rnd(); set_src(ab, src);
      settle(); chk("R2/R1 transparent flow", dst(ab), expect_out(1'b1, src, held));
    end
    step(); set_cp(ab, 1'b1);
    step(); src = rnd(); set_src(ab, src);
    settle(); chk("R7 rising edge while transparent", dst(ab), src);
    step(); set_cp(ab, 1'b0);
    step(); held = src; set_le(ab, 1'b0);
    settle(); chk("R5 value kept on latch enable fall", dst(ab), held);
    for (int i = 0; i < 3; i++) begin
      step(); src = rnd(); set_src(ab, src);
      settle(); chk("R3 hold with clock low", dst(ab), expect_out(1'b0, src, held));
    end
    step(); set_cp(ab, 1'b1); held = src;
    settle(); chk("R4 rising edge capture", dst(ab), held);
    for (int i = 0; i < 3; i++) begin
      step(); src = rnd(); set_src(ab, src);
      settle(); chk("R3 hold with clock high", dst(ab), held);
    end
    step(); src = rnd(); set_src(ab, src);
    step(); set_cp(ab, 1'b0);
    settle(); chk("R6 falling edge no load", dst(ab), held);
    for (int i = 0; i < 8; i++) begin
      step(); src = rnd(); set_src(ab, src);
      step(); set_cp(ab, 1'b1); held = src;
      step(); set_src(ab, rnd());
      settle(); chk("R4 random capture", dst(ab), held);
      step(); set_cp(ab, 1'b0);
    end
    step(); set_oe_n(ab, 1'b1);
    step(); set_dst_drive(ab, 1'b1, ~held);
    settle(); chk("R8 released bus readback", dst(ab), ~held);
    step(); set_dst_drive(ab, 1'b1, rnd() ^ 18'h15A5A);
    settle(); chk("R8 released bus second word", dst(ab), ab ? b_drv : a_drv);
    step(); set_dst_drive(ab, 1'b0, '0);
    step(); set_oe_n(ab, 1'b0);
    settle(); chk("R9 re-enable shows stored word", dst(ab), held);
    step(); set_oe_n(ab, 1'b1);
    final_held = held;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    a_drv = '0; b_drv = '0; a_en = 1'b1; b_en = 1'b1;
    oe_ab_n = 1'b1; oe_ba_n = 1'b1;
    le_ab = 1'b1; le_ba = 1'b1; cp_ab = 1'b0; cp_ba = 1'b0;
    settle();
    chk("R8 both released at start (A)", a_io, '0);
    chk("R8 both released at start (B)", b_io, '0);

    a_en = 1'b1;
    run_path(1'b1, held_ab);
    step(); b_en = 1'b1; a_en = 1'b0;
    run_path(1'b0, held_ba);

    step(); b_en = 1'b0; a_en = 1'b0;
    oe_ab_n = 1'b0;
    settle(); chk("R10 A-to-B storage untouched by B-to-A traffic", b_io, held_ab);
    step(); oe_ba_n = 1'b0;
    settle();
    chk("R11 swap B shows A-to-B word", b_io, held_ab);
    chk("R11 swap A shows B-to-A word", a_io, held_ba);
    step(); oe_ab_n = 1'b1; oe_ba_n = 1'b1;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule